// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire bus slave that fills a bank of thirty-two byte-wide configuration registers and answers reads with a single live status byte. A write transfer opens with the device address and a write direction bit. A control byte follows, carrying a register index, an auto-increment enable and a test flag. Any number of data bytes may then follow, each acknowledged and each stored in the bank. The register contents are presented in parallel to the processing logic, and every stored byte also produces a one-cycle strobe with its index and value.

A read transfer returns a status byte made from two inputs: a soft-step busy flag, sent inverted so that 0 means busy, and a soft-mute active flag. The byte is sampled again each time the master acknowledges, so a master can poll the status by clocking out byte after byte without addressing the device a second time. Both bus lines are brought into the system clock domain through two-stage synchronisers. The block takes SDA low only while SCL is low, by asserting an output-enable that the pad turns into an open-drain pull-down.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits are 1000100; bit 0 of that byte selects write (0) or read (1). Any other address gets no acknowledge, and the transfer that follows changes no register.
- R2: The control byte after a write address is decoded as follows: bits 4:0 are the register index, bit 5 turns on auto-increment, bit 7 is the test flag, and bit 6 has no effect.
- R3: Each data byte of a write is acknowledged and stored in the indexed register. The store raises `wrStrobe` for exactly one clock, together with the index and the data.
- R4: When auto-increment is on, the index moves up by one after each data byte and wraps from 31 to 0.
- R5: When auto-increment is off, every data byte of the transfer goes to the same register.
- R6: A read byte is sent MSB first and holds the inverted busy input in bit 1, the mute input in bit 0, and zeros in bits 7:2.
- R7: After a master acknowledge the status is sampled again and a further byte is sent with no new address. A master not-acknowledge ends the read.
- R8: After reset every register holds `DEFAULT_VAL`, SDA is released, no strobe is active and `testArmed` is low.
- R9: `testArmed` is high only when the test flag of the most recent control byte is set and bit 0 of register 20 is set.
- R10: A stop condition at any point ends the transfer and discards any partial byte. A start condition at any point begins a new address phase.
- R11: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| busyIn | input | 1 | Soft-step operation in progress |
| muteIn | input | 1 | Soft mute active |
| regFlat | output | 256 | Register bank; register i occupies bits 8i+7:8i |
| wrStrobe | output | 1 | One-cycle pulse for each stored byte |
| wrIndex | output | 5 | Index of the stored byte |
| wrData | output | 8 | Value of the stored byte |
| wrTest | output | 1 | Test flag in effect for the stored byte |
| testArmed | output | 1 | Test flag combined with the test-enable register bit |

## Verification
A table of write transfers varies the control byte. One row starts mid-bank with auto-increment on, one crosses the 31-to-0 wrap, one keeps a fixed index, one sets the unused bit 6, and two set the test flag with the enable bit written as 1 and then as 0. Between them, these rows separate correct index stepping from stuck, off-by-one or unwrapped pointers, and separate correct flag decoding from decoding that uses the wrong bit. Directed transfers then cover an address that must be ignored, a two-byte status poll whose inputs change between the bytes, a stop in the middle of a byte, and a repeated start after a control byte. These show whether the address compare, the resampling at each acknowledge and the abort paths behave correctly.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_SUB,
    ST_ACK_SUB,
    ST_WDATA,
    ST_ACK_DATA,
    ST_RDATA,
    ST_RACK
  } busState_t;

  typedef struct packed {
    logic rxBit;
    logic shiftIn;
    logic loadSub;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
  } ctrlStrobes_t;

endpackage

// File: rtl/cfg_i2c_ctrl.sv
module cfg_i2c_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic [7:0]   rxByte,
  input  logic         txMsb,
  output ctrlStrobes_t strb,
  output logic         sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclS, sdaS, sclD, sdaD;
  logic       sclRise, sclFall, startCond, stopCond;
  busState_t  state;
  logic [3:0] bitCnt;
  logic       isRead, driveAck, txActive, masterAck;
  logic       rxState;

  // two-stage synchronisers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;
  assign rxState   = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);

  always_comb begin
    strb           = '0;
    strb.rxBit     = sdaS;
    if (!startCond && !stopCond) begin
      strb.shiftIn   = sclRise && rxState && (bitCnt < 4'd8);
      strb.loadSub   = sclFall && (state == ST_SUB) && (bitCnt == 4'd8);
      strb.writeByte = sclFall && (state == ST_WDATA) && (bitCnt == 4'd8);
      strb.loadTx    = sclFall && (((state == ST_ACK_ADDR) && isRead) ||
                                   ((state == ST_RACK) && masterAck));
      strb.shiftTx   = sclFall && (state == ST_RDATA) && (bitCnt != 4'd8);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      driveAck  <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startCond) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      driveAck <= 1'b0;
      txActive <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      driveAck <= 1'b0;
      txActive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                driveAck <= 1'b1;
                isRead   <= rxByte[0];
                state    <= ST_ACK_ADDR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              driveAck <= 1'b1;
              state    <= (state == ST_SUB) ? ST_ACK_SUB : ST_ACK_DATA;
            end
          end
        end
        ST_ACK_ADDR, ST_ACK_SUB, ST_ACK_DATA: begin
          if (sclFall) begin
            driveAck <= 1'b0;
            bitCnt   <= '0;
            if (state == ST_ACK_ADDR && isRead) begin
              state    <= ST_RDATA;
              txActive <= 1'b1;
            end else if (state == ST_ACK_ADDR) begin
              state <= ST_SUB;
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            txActive <= 1'b0;
            state    <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            masterAck <= ~sdaS;
          end else if (sclFall) begin
            bitCnt <= '0;
            if (masterAck) begin
              state    <= ST_RDATA;
              txActive <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaOe = driveAck | (txActive & ~txMsb);

  // R1: an idle slave never holds the data line
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R11: the drive changes only while SCL is low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  // R3: datapath strobes never overlap
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.loadSub, strb.writeByte, strb.loadTx, strb.shiftTx}));

endmodule

// File: rtl/cfg_i2c_dpath.sv
module cfg_i2c_dpath
  import cfg_i2c_pkg::*;
#(
  parameter int         IDX_W       = 5,
  parameter logic [7:0] DEFAULT_VAL = 8'h00,
  parameter int         TEST_REG    = 20,
  parameter int         TEST_BIT    = 0,
  localparam int        NUM_REGS    = 2 ** IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic                  busyIn,
  input  logic                  muteIn,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex,
  output logic [7:0]            wrData,
  output logic                  wrTest,
  output logic                  testArmed
);

  logic [7:0]       rxShift, txShift;
  logic [7:0]       regs [NUM_REGS];
  logic [IDX_W-1:0] ptr;
  logic             autoInc, testFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      ptr      <= '0;
      autoInc  <= 1'b0;
      testFlag <= 1'b0;
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
      wrData   <= '0;
      wrTest   <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= DEFAULT_VAL;
    end else begin
      wrStrobe <= 1'b0;
      if (strb.shiftIn) rxShift <= {rxShift[6:0], strb.rxBit};
      if (strb.loadSub) begin
        ptr      <= rxShift[IDX_W-1:0];
        autoInc  <= rxShift[5];
        testFlag <= rxShift[7];
      end
      if (strb.writeByte) begin
        regs[ptr] <= rxShift;
        wrStrobe  <= 1'b1;
        wrIndex   <= ptr;
        wrData    <= rxShift;
        wrTest    <= testFlag;
        if (autoInc) ptr <= ptr + 1'b1;
      end
      if (strb.loadTx)       txShift <= {6'b000000, ~busyIn, muteIn};
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign rxByte    = rxShift;
  assign txMsb     = txShift[7];
  assign testArmed = testFlag & regs[TEST_REG][TEST_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regFlat[g*8 +: 8] = regs[g];
  end

  // R3: the strobe is a single-cycle pulse
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R3: the reported byte is what the bank holds
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (regs[wrIndex] == wrData));

  // R4: the index wraps from the top register to zero
  p_index_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && autoInc && (ptr == {IDX_W{1'b1}})) |=> (ptr == '0));

  // R5: without auto-increment the index holds
  p_index_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && !autoInc) |=> $stable(ptr));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         IDX_W       = 5,
  parameter logic [7:0] DEFAULT_VAL = 8'h00,
  parameter int         TEST_REG    = 20,
  parameter int         TEST_BIT    = 0,
  localparam int        NUM_REGS    = 2 ** IDX_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic                  busyIn,
  input  logic                  muteIn,
  output logic [NUM_REGS*8-1:0] regFlat,
  output logic                  wrStrobe,
  output logic [IDX_W-1:0]      wrIndex,
  output logic [7:0]            wrData,
  output logic                  wrTest,
  output logic                  testArmed
);

  ctrlStrobes_t strb;
  logic [7:0]   rxByte;
  logic         txMsb;

  cfg_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxByte (rxByte),
    .txMsb  (txMsb),
    .strb   (strb),
    .sdaOe  (sdaOe)
  );

  cfg_i2c_dpath #(
    .IDX_W      (IDX_W),
    .DEFAULT_VAL(DEFAULT_VAL),
    .TEST_REG   (TEST_REG),
    .TEST_BIT   (TEST_BIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busyIn    (busyIn),
    .muteIn    (muteIn),
    .rxByte    (rxByte),
    .txMsb     (txMsb),
    .regFlat   (regFlat),
    .wrStrobe  (wrStrobe),
    .wrIndex   (wrIndex),
    .wrData    (wrData),
    .wrTest    (wrTest),
    .testArmed (testArmed)
  );

endmodule

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;

  localparam int         QTR  = 10;
  localparam logic [7:0] DEFV = 8'h00;

  // {control byte, data0, data1, data2}
  localparam logic [31:0] VEC [6] = '{
    32'h23_A1_A2_A3,   // auto-inc from 3
    32'h3E_B1_B2_B3,   // wrap 30,31,0
    32'h0A_C1_C2_C3,   // fixed index 10
    32'h4C_D1_D2_D3,   // bit 6 set, fixed index 12
    32'hB4_01_55_66,   // test flag, enable bit written 1
    32'h94_00_E0_00    // test flag, fixed index 20, enable bit ends 0
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic busyIn = 1'b0, muteIn = 1'b0;
  logic sdaOe, wrStrobe, wrTest, testArmed;
  logic [255:0] regFlat;
  logic [4:0]   wrIndex;
  logic [7:0]   wrData;
  wire          sdaLine = sdaM & ~sdaOe;

  int tests = 0, fails = 0;
  int logCnt = 0;
  logic [4:0] logIdx [256];
  logic [7:0] logDat [256];
  logic       logTst [256];
  logic [7:0] expRegs [32];

  always #10 clk = ~clk;

  cfg_i2c_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .busyIn(busyIn), .muteIn(muteIn), .regFlat(regFlat),
    .wrStrobe(wrStrobe), .wrIndex(wrIndex), .wrData(wrData),
    .wrTest(wrTest), .testArmed(testArmed)
  );

  always @(negedge clk) begin
    if (wrStrobe && logCnt < 256) begin
      logIdx[logCnt] <= wrIndex;
      logDat[logCnt] <= wrData;
      logTst[logCnt] <= wrTest;
      logCnt <= logCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkBank(input string req);
    int bad = -1;
    for (int i = 0; i < 32; i++)
      if (bad < 0 && regFlat[i*8 +: 8] !== expRegs[i]) bad = i;
    tests++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: reg %0d actual %0h expected %0h", req, bad,
               regFlat[bad*8 +: 8], expRegs[bad]);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic busStop();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; q(); sclM = 1'b1; q(); b = sdaLine; q(); sclM = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic bit_v;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(bit_v);
    acked = ~bit_v;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic giveAck);
    logic bit_v;
    for (int i = 7; i >= 0; i--) begin
      recvBit(bit_v);
      d[i] = bit_v;
    end
    sendBit(~giveAck);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] rd;
    int base;

    for (int i = 0; i < 32; i++) expRegs[i] = DEFV;
    repeat (5) @(negedge clk);
    // R8: reset state
    checkBank("R8 bank default");
    check("R8 sda released", sdaOe, 0);
    check("R8 no strobe", wrStrobe, 0);
    check("R8 testArmed low", testArmed, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // table of write transfers: R2 R3 R4 R5 R9
    for (int v = 0; v < 6; v++) begin
      logic [7:0] sub;
      logic [4:0] idx;
      logic       allAck;
      sub = VEC[v][31:24];
      base = logCnt;
      allAck = 1'b1;
      busStart();
      sendByte(8'h88, ack); allAck &= ack;
      sendByte(sub, ack);   allAck &= ack;
      for (int k = 0; k < 3; k++) begin
        sendByte(VEC[v][23-8*k -: 8], ack); allAck &= ack;
      end
      busStop();
      q();
      check($sformatf("R3 acks vec%0d", v), allAck, 1);
      check($sformatf("R3 strobe count vec%0d", v), logCnt - base, 3);
      idx = sub[4:0];
      for (int k = 0; k < 3; k++) begin
        // R4 wrap / R5 fixed index
        check($sformatf("R4/R5 index vec%0d byte%0d", v, k), logIdx[base+k], idx);
        check($sformatf("R3 data vec%0d byte%0d", v, k), logDat[base+k], VEC[v][23-8*k -: 8]);
        check($sformatf("R2 test flag vec%0d", v), logTst[base+k], sub[7]);
        expRegs[idx] = VEC[v][23-8*k -: 8];
        if (sub[5]) idx = idx + 5'd1;
      end
      checkBank($sformatf("R2 bank vec%0d", v));
      if (v == 4) check("R9 armed", testArmed, 1);
      if (v == 5) check("R9 disarmed", testArmed, 0);
    end

    // R1: wrong address ignored
    base = logCnt;
    busStart();
    sendByte(8'h8A, ack);
    check("R1 no ack wrong addr", ack, 0);
    sendByte(8'h21, ack);
    sendByte(8'h77, ack);
    busStop(); q();
    check("R1 no strobe wrong addr", logCnt - base, 0);
    checkBank("R1 bank unchanged");

    // R6 R7: status polling
    busyIn = 1'b1; muteIn = 1'b0;
    busStart();
    sendByte(8'h89, ack);
    check("R1 ack read addr", ack, 1);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recvBit(b);
      rd[i] = b;
    end
    check("R6 status busy", rd, 8'h00);
    busyIn = 1'b0; muteIn = 1'b1;
    sendBit(1'b0);
    recvByte(rd, 1'b0);
    check("R7 status refreshed", rd, 8'h03);
    check("R7 released after nack", sdaOe, 0);
    busStop(); q();

    // R10: stop in the middle of a byte
    base = logCnt;
    busStart();
    sendByte(8'h88, ack);
    sendByte(8'h07, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop(); q();
    check("R10 partial byte dropped", logCnt - base, 0);
    checkBank("R10 bank after abort");

    // R10: repeated start after control byte
    base = logCnt;
    busStart();
    sendByte(8'h88, ack);
    sendByte(8'h05, ack);
    busStart();
    sendByte(8'h88, ack);
    sendByte(8'h06, ack);
    sendByte(8'h5A, ack);
    busStop(); q();
    check("R10 restart strobe count", logCnt - base, 1);
    check("R10 restart index", logIdx[base], 6);
    expRegs[6] = 8'h5A;
    checkBank("R10 bank after restart");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule